// File: doc/BRIEF.md
# Fieldbus Telegram Character Receiver

This block turns an asynchronous serial line into received characters and marks where each telegram begins. Each character is eleven bit times long: a low start bit, eight data bits least significant first, an even parity bit and a high stop bit. The line is oversampled at sixteen times the bit rate. The oversampling tick is derived from a divisor input, so the bit rate can be changed at run time without rebuilding the block. Each bit is decided by a majority vote of three samples taken at the middle of the bit.

Alongside the character path, a timer measures how long the line has been high without a break. A telegram begins only after the line has been high for a full sync gap of 33 bit times. The first start bit after such a gap raises a one-cycle telegram-start pulse, and from then on characters are delivered on the byte-valid strobe. A character that arrives while no telegram is open goes out on a separate stray strobe instead. Parity and framing errors are reported in the same cycle as the strobe that carries the character. A framing error closes the telegram, so a fresh sync gap is needed before content is accepted again.

Top module: `fbus_char_rx`

## Requirements
- R1: A character is a low start bit, eight data bits sent least significant bit first, a parity bit and a stop bit. The received data appears on `byte_o` in the same cycle as its strobe, and `byte_o` keeps its value between strobes.
- R2: The oversampling tick fires once every `max(os_div_i,1)` clock cycles, and one bit lasts 16 ticks. The first tick that sees the line low is tick 0 of the start bit. Each bit is decided by a majority of the samples at ticks 7, 8 and 9 of that bit.
- R3: If the start bit's majority reads high, the start is discarded and no strobe of any kind follows.
- R4: `parity_err_o` is 1 alongside the strobe when the total number of ones in the eight data bits and the parity bit is odd, and 0 otherwise.
- R5: `frame_err_o` is 1 alongside the strobe when the stop bit's majority reads low.
- R6: The sync gap counts whole bit times (16 ticks each) of unbroken high samples, and it is complete once the count reaches 33. A single low sample clears the count, so a gap that is even one bit time short does not open a telegram.
- R7: `tel_start_o` pulses for exactly one cycle, in the middle of the start bit of the first character after a complete sync gap, and before that character's strobe.
- R8: Once a telegram is open, each character is reported on `byte_valid_o`. When no telegram is open, each character is reported on `stray_o`. Both strobes last one cycle and are never high together. Errors are reported only together with one of the strobes.
- R9: A character with a framing error is still reported. After it the telegram is closed, so the characters that follow go to `stray_o` until the next complete sync gap.
- R10: While `rst` is high and in the cycle after it, every strobe and error output is 0, `byte_o` is 0 and no telegram is open.
- R11: A divisor value of 0 behaves exactly like a divisor of 1, giving 16 clock cycles per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Asynchronous serial line, high when idle |
| os_div_i | input | DIV_W | Clock cycles per oversampling tick (0 is treated as 1) |
| byte_o | output | DATA_BITS | Last received data byte |
| byte_valid_o | output | 1 | One-cycle strobe for a character inside a telegram |
| stray_o | output | 1 | One-cycle strobe for a character outside any telegram |
| parity_err_o | output | 1 | Parity error, valid with a strobe |
| frame_err_o | output | 1 | Stop bit read low, valid with a strobe |
| tel_start_o | output | 1 | One-cycle pulse at the start bit that opens a telegram |

## Verification
The hardest condition to reach is the edge of the sync gap. The high run the timer sees includes the stop bit of the previous character, plus its parity bit and any high data bits just before it. The line therefore has to be controlled exactly, across character boundaries, to land just below or just above 33 bit times. The stimulus places gaps after characters whose parity bit is 0, so the run is the stop bit plus the gap. It then compares a run of 32 bit times, which must not open a telegram, against a run of 34, which must. A short low glitch during idle is also driven. It must produce no character and must restart the gap count, so a later character goes out without a telegram-start pulse. The divisor is changed between segments so that the bit timing is also checked at the smallest and at a larger tick period.

// File: rtl/fbus_rx_pkg.sv
package fbus_rx_pkg;

  localparam int unsigned OS_RATE = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_SHIFT,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/fbus_os_tick.sv
module fbus_os_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  // a divisor of zero is treated as one
  assign last = (div_i == '0) ? '0 : div_i - DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt >= last) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + DIV_W'(1);
      tick_o <= 1'b0;
    end
  end

endmodule

// File: rtl/fbus_idle_timer.sv
module fbus_idle_timer #(
  parameter int unsigned OS        = 16,
  parameter int unsigned IDLE_BITS = 33
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic line_i,
  output logic sync_o
);

  localparam int unsigned TW = $clog2(OS);
  localparam int unsigned BW = $clog2(IDLE_BITS + 1);

  logic [TW-1:0] tick_cnt;
  logic [BW-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      bit_cnt  <= '0;
    end else if (tick_i) begin
      if (!line_i) begin
        tick_cnt <= '0;
        bit_cnt  <= '0;
      end else if (tick_cnt == TW'(OS - 1)) begin
        tick_cnt <= '0;
        if (bit_cnt != BW'(IDLE_BITS)) begin
          bit_cnt <= bit_cnt + BW'(1);
        end
      end else begin
        tick_cnt <= tick_cnt + TW'(1);
      end
    end
  end

  assign sync_o = (bit_cnt == BW'(IDLE_BITS));

endmodule

// File: rtl/fbus_char_fsm.sv
module fbus_char_fsm
  import fbus_rx_pkg::*;
#(
  parameter int unsigned OS    = 16,
  parameter int unsigned NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             line_i,
  input  logic             sync_i,
  output logic [NBITS-1:0] data_o,
  output logic             valid_o,
  output logic             stray_o,
  output logic             perr_o,
  output logic             ferr_o,
  output logic             tstart_o
);

  localparam int unsigned TW    = $clog2(OS);
  localparam int unsigned BW    = $clog2(NBITS + 1);
  localparam int unsigned MID_A = OS / 2 - 1;
  localparam int unsigned MID_B = OS / 2;
  localparam int unsigned MID_C = OS / 2 + 1;

  rx_state_e        state;
  logic [TW-1:0]    tcnt;
  logic [BW-1:0]    bidx;
  logic [NBITS-1:0] shreg;
  logic             par;
  logic             v0, v1;
  logic             armed;
  logic             in_tel;
  logic             bitval;

  assign bitval = maj3(v0, v1, line_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      shreg    <= '0;
      par      <= 1'b0;
      v0       <= 1'b1;
      v1       <= 1'b1;
      armed    <= 1'b0;
      in_tel   <= 1'b0;
      data_o   <= '0;
      valid_o  <= 1'b0;
      stray_o  <= 1'b0;
      perr_o   <= 1'b0;
      ferr_o   <= 1'b0;
      tstart_o <= 1'b0;
    end else begin
      valid_o  <= 1'b0;
      stray_o  <= 1'b0;
      perr_o   <= 1'b0;
      ferr_o   <= 1'b0;
      tstart_o <= 1'b0;
      if (tick_i) begin
        if (state == ST_IDLE) begin
          if (!line_i) begin
            state <= ST_START;
            tcnt  <= TW'(1);
            armed <= sync_i;
          end
        end else begin
          tcnt <= (tcnt == TW'(OS - 1)) ? '0 : tcnt + TW'(1);
          if (tcnt == TW'(MID_A)) v0 <= line_i;
          if (tcnt == TW'(MID_B)) v1 <= line_i;
          if (tcnt == TW'(MID_C)) begin
            unique case (state)
              ST_START: begin
                if (bitval) begin
                  state <= ST_IDLE;
                end else begin
                  state <= ST_SHIFT;
                  bidx  <= '0;
                  if (armed) begin
                    in_tel   <= 1'b1;
                    tstart_o <= 1'b1;
                  end
                end
              end
              ST_SHIFT: begin
                if (bidx < BW'(NBITS)) begin
                  shreg <= {bitval, shreg[NBITS-1:1]};
                  bidx  <= bidx + BW'(1);
                end else begin
                  par   <= bitval;
                  state <= ST_STOP;
                end
              end
              ST_STOP: begin
                data_o  <= shreg;
                perr_o  <= (^shreg) ^ par;
                ferr_o  <= !bitval;
                valid_o <= in_tel;
                stray_o <= !in_tel;
                if (!bitval) in_tel <= 1'b0;
                state   <= ST_IDLE;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/fbus_char_rx.sv
module fbus_char_rx
  import fbus_rx_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned IDLE_BITS = 33,
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxd_i,
  input  logic [DIV_W-1:0]     os_div_i,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 byte_valid_o,
  output logic                 stray_o,
  output logic                 parity_err_o,
  output logic                 frame_err_o,
  output logic                 tel_start_o
);

  logic [1:0] sync_ff;
  logic       line;
  logic       tick;
  logic       gap_done;

  always_ff @(posedge clk) begin
    if (rst) sync_ff <= 2'b11;
    else     sync_ff <= {sync_ff[0], rxd_i};
  end
  assign line = sync_ff[1];

  fbus_os_tick #(.DIV_W(DIV_W)) i_tick (
    .clk    (clk),
    .rst    (rst),
    .div_i  (os_div_i),
    .tick_o (tick)
  );

  fbus_idle_timer #(.OS(OS_RATE), .IDLE_BITS(IDLE_BITS)) i_idle (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick),
    .line_i (line),
    .sync_o (gap_done)
  );

  fbus_char_fsm #(.OS(OS_RATE), .NBITS(DATA_BITS)) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .line_i   (line),
    .sync_i   (gap_done),
    .data_o   (byte_o),
    .valid_o  (byte_valid_o),
    .stray_o  (stray_o),
    .perr_o   (parity_err_o),
    .ferr_o   (frame_err_o),
    .tstart_o (tel_start_o)
  );

endmodule

// File: rtl/fbus_char_rx_chk.sv
module fbus_char_rx_chk #(
  parameter int unsigned DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DATA_BITS-1:0] byte_o,
  input logic                 byte_valid_o,
  input logic                 stray_o,
  input logic                 parity_err_o,
  input logic                 frame_err_o,
  input logic                 tel_start_o
);

  p_one_route_r8: assert property (@(posedge clk) disable iff (rst)
    !(byte_valid_o && stray_o));

  p_tel_start_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    tel_start_o |=> !tel_start_o);

  p_parity_with_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    parity_err_o |-> (byte_valid_o || stray_o));

  p_frame_with_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> (byte_valid_o || stray_o));

  p_byte_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!byte_valid_o && !stray_o) |-> $stable(byte_o));

  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> (!byte_valid_o && !stray_o && !tel_start_o &&
             !parity_err_o && !frame_err_o && byte_o == '0));

endmodule

bind fbus_char_rx fbus_char_rx_chk #(.DATA_BITS(DATA_BITS)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .byte_o       (byte_o),
  .byte_valid_o (byte_valid_o),
  .stray_o      (stray_o),
  .parity_err_o (parity_err_o),
  .frame_err_o  (frame_err_o),
  .tel_start_o  (tel_start_o)
);

// File: tb/test_fbus_char_rx.sv
module test_fbus_char_rx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic [15:0] div = 16'd2;
  logic [7:0]  byte_o;
  logic        byte_valid_o, stray_o, parity_err_o, frame_err_o, tel_start_o;

  always #2 clk = ~clk;

  fbus_char_rx i_fbus_char_rx (
    .clk          (clk),
    .rst          (rst),
    .rxd_i        (rxd),
    .os_div_i     (div),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .stray_o      (stray_o),
    .parity_err_o (parity_err_o),
    .frame_err_o  (frame_err_o),
    .tel_start_o  (tel_start_o)
  );

  typedef struct {
    logic [7:0] d;
    bit pe;
    bit fe;
    bit val;
    bit ts;
  } exp_t;

  exp_t q[$];
  bit   ts_seen = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  int   run_bits = 0;
  bit   in_tel_m = 0;
  bit   done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (tel_start_o) begin
        if (q.size() == 0) chk("R7 unexpected telegram start", 1, 0);
        else begin
          chk("R7 telegram start expected", 1, int'(q[0].ts));
          chk("R7 single start per char", int'(ts_seen), 0);
        end
        ts_seen = 1;
      end
      if (byte_valid_o || stray_o) begin
        if (q.size() == 0) chk("R3 unexpected character strobe", 1, 0);
        else begin
          chk("R1 data", int'(byte_o), int'(q[0].d));
          chk("R4 parity error", int'(parity_err_o), int'(q[0].pe));
          chk("R5 framing error", int'(frame_err_o), int'(q[0].fe));
          chk("R8 valid strobe", int'(byte_valid_o), int'(q[0].val));
          chk("R9 stray strobe", int'(stray_o), int'(!q[0].val));
          chk("R7 start before strobe", int'(ts_seen), int'(q[0].ts));
          void'(q.pop_front());
        end
        ts_seen = 0;
      end else if (parity_err_o || frame_err_o) begin
        chk("R8 error without strobe", 1, 0);
      end
    end
  end

  function automatic int cpb();
    return 16 * ((div == 0) ? 1 : int'(div));
  endfunction

  task automatic drive_bit(input bit b);
    rxd = b;
    repeat (cpb()) @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b1);
    run_bits += n;
  endtask

  task automatic glitch(input int cycles);
    rxd = 1'b0;
    repeat (cycles) @(posedge clk);
    #1;
    rxd = 1'b1;
    run_bits = 0;
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    exp_t e;
    bit p;
    bit sync;
    if (run_bits == 33) $display("note: ambiguous gap length in stimulus");
    p    = (^d) ^ bad_par;
    sync = (run_bits >= 34);
    if (sync) in_tel_m = 1;
    e.d = d; e.pe = bad_par; e.fe = bad_stop; e.val = in_tel_m; e.ts = sync;
    q.push_back(e);
    if (bad_stop) in_tel_m = 0;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(p);
    drive_bit(!bad_stop);
    rxd = 1'b1;
    if (bad_stop) run_bits = 0;
    else begin
      run_bits = 1;
      if (p) begin
        run_bits++;
        for (int i = 7; i >= 0; i--) begin
          if (!d[i]) break;
          run_bits++;
        end
      end
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 byte after reset", int'(byte_o), 0);
    chk("R10 strobes after reset", int'({byte_valid_o, stray_o, tel_start_o}), 0);
    chk("R10 errors after reset", int'({parity_err_o, frame_err_o}), 0);
    @(posedge clk);
    #1;
    // R8 character before any sync gap
    idle(5);
    send(8'hA5, 0, 0);
    // R6 R7 full gap opens a telegram; R1 R2 back-to-back patterns
    idle(40);
    send(8'h3C, 0, 0);
    send(8'h81, 0, 0);
    send(8'h00, 0, 0);
    send(8'hFF, 0, 0);
    // R4 parity error
    send(8'h5A, 1, 0);
    // R5 R9 framing error closes the telegram
    idle(2);
    send(8'h12, 0, 1);
    idle(3);
    send(8'h34, 0, 0);
    // R6 gap boundary: 32 bit times no start, 34 bit times start
    idle(40);
    send(8'h03, 0, 0);
    idle(31);
    send(8'h77, 0, 0);
    idle(33);
    send(8'h44, 0, 0);
    // R3 glitch rejected and clears the gap count
    idle(40);
    glitch(4);
    idle(10);
    send(8'h66, 0, 0);
    // R11 divisor zero behaves as one
    div = 16'd0;
    idle(40);
    send(8'hC3, 0, 0);
    send(8'h99, 1, 0);
    // R2 slower tick
    div = 16'd5;
    idle(40);
    send(8'hE7, 0, 0);
    idle(5);
    chk("R1 all characters delivered", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule